// File: doc/BRIEF.md
# Serial Port Register Block with Receive Queue

This block is the register side of a serial port that sits on a 32-bit peripheral bus. It decodes word-aligned accesses and holds the configuration registers: line setup, control, the two baud divisors, low-power divisor, queue-level select, and DMA enable. A write to the data register passes its low byte to a one-cycle transmit strobe. Received bytes arrive on a push port and wait in a 16-entry queue until software reads the data register.

The block keeps receive-full and receive-empty flags that follow the occupancy count. It has two raw interrupt sources, transmit and receive. Each source has a mask bit, a masked view and a write-one-to-clear register, and the interrupt line is the OR of the masked bits. A fixed eight-byte identification pattern can be read from the top of the address space. Bit timing, shifters and DMA handshakes are not part of this block. Only the behaviour that software sees through the registers is modelled.

Top module: `uart_regfile`

## Requirements
- R1: After reset, the registers read as follows: flags (word 6) 0x90, control (word 12) 0x300, level select (word 13) 0x12. Line setup (word 11), mask (word 14), raw status (word 15) and receive status (word 1) read 0, and `irq` is low.
- R2: A write to word 0 raises `tx_valid` for exactly one cycle, starting the cycle after the write, with `tx_byte` equal to the written bits [7:0]. The same write sets raw status bit 5, the transmit interrupt.
- R3: Pushed bytes are read back from word 0 oldest first, in bits [7:0]. A read of word 0 with the queue empty returns 0. A push while 16 bytes are held is discarded.
- R4: Flag bit 4 (receive empty) clears on an accepted push and sets when a read of word 0 leaves the count at 0.
- R5: Flag bit 6 (receive full) sets on a push in either of two cases: line-setup bit 4 is 0 (queue mode off), or the count reaches 16. Every read of word 0 clears it.
- R6: Raw status bit 4 (receive interrupt) sets when a push leaves the count at or above the trigger level of 1. It clears when a read of word 0 leaves the count one below the trigger level.
- R7: A write to word 11 that changes bit 4 empties the queue: the count goes to 0, the empty flag sets and the full flag clears. A write that keeps bit 4 unchanged leaves the queue as it was.
- R8: A write to word 17 clears each raw status bit written as 1 and leaves the other bits alone. Word 16 reads as raw status AND mask (word 14), and `irq` is the OR of the masked bits.
- R9: Words 8, 9, 10, 11, 12, 13, 14 and 18 each read back the full 32-bit value last written to them.
- R10: A write to word 6 is accepted without an error and changes no flag. A write to word 1 is accepted without an error, and word 1 then reads 0.
- R11: Reads at words 0x3F8 to 0x3FF return, in ascending address order, 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05 and 0xB1.
- R12: A write to any word that is not writable raises `bus_err` for one cycle and changes no state. This covers words 15 and 16, the identification window and unassigned words. A read of an unassigned word (for example word 17 or word 2) returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset; bits [11:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| rx_valid | input | 1 | Push one received byte |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | One-cycle strobe for a transmitted byte |
| tx_byte | output | 8 | Transmitted byte |
| irq | output | 1 | Combined masked interrupt |
| bus_err | output | 1 | One-cycle pulse after a write to a non-writable word |

## Verification
The bench goes after the queue edges. It fills the queue to exactly 16, pushes a seventeenth byte and drains one read past empty. A design with an off-by-one in the limit would either return the dropped byte or lose the sixteenth. It also checks that the full flag follows queue mode. With the queue off, a single push must raise the full flag, so a design that only compares the count against 16 shows it clear. It toggles line-setup bit 4 with the queue part-full, and also rewrites that register with bit 4 unchanged. A design that flushes on every line-setup write loses data, and one that never flushes keeps returning stale bytes. A write-one-to-clear with a single bit set, made while both interrupts are pending, exposes a design that clears the whole status register. Writes to the read-only status words must raise the error pulse and leave the status unchanged.

// File: rtl/uart_regfile.sv
`timescale 1ns/1ps
module uart_regfile #(
  parameter int ADDR_W     = 12,
  parameter int FIFO_DEPTH = 16,
  parameter int RX_TRIG    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic              irq,
  output logic              bus_err
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam int WRD_W = ADDR_W - 2;
  localparam logic [WRD_W-1:0] W_DATA = 0, W_RSR = 1, W_FLAG = 6, W_ILPR = 8,
    W_IBRD = 9, W_FBRD = 10, W_LCR = 11, W_CR = 12, W_IFLS = 13, W_IMSC = 14,
    W_RIS = 15, W_MIS = 16, W_ICR = 17, W_DMACR = 18, W_ID = 10'h3F8;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(FIFO_DEPTH);
  localparam logic [CNT_W-1:0] TRIG_C  = CNT_W'(RX_TRIG);

  logic [WRD_W-1:0] word;
  logic             wr, rd, pop_req, do_pop, flush, push_ok, wr_known, in_id;
  logic [CNT_W-1:0] count, cnt_after_pop, cnt_next;
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [7:0]       mem [FIFO_DEPTH];
  logic [31:0]      ilpr, ibrd, fbrd, lcr, cr, ifls, imsc, dmacr;
  logic [1:0]       ris;
  logic             flag_full, flag_empty;
  logic             unused_bits;

  assign unused_bits   = ^bus_addr[1:0];
  assign word          = bus_addr[ADDR_W-1:2];
  assign wr            = bus_en & bus_we;
  assign rd            = bus_en & ~bus_we;
  assign pop_req       = rd && (word == W_DATA);
  assign do_pop        = pop_req && (count != '0);
  assign flush         = wr && (word == W_LCR) && (bus_wdata[4] != lcr[4]);
  assign cnt_after_pop = count - CNT_W'(do_pop);
  assign push_ok       = rx_valid && !flush && (cnt_after_pop < DEPTH_C);
  assign cnt_next      = cnt_after_pop + CNT_W'(push_ok);
  assign in_id         = (word >= W_ID) && (word < W_ID + 8);
  assign wr_known      = word inside {W_DATA, W_RSR, W_FLAG, W_ILPR, W_IBRD, W_FBRD,
                                      W_LCR, W_CR, W_IFLS, W_IMSC, W_ICR, W_DMACR};
  assign irq           = |(ris & imsc[5:4]);

  always_ff @(posedge clk)
    if (push_ok) mem[wr_ptr] <= rx_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0; rd_ptr <= '0; wr_ptr <= '0;
      flag_full <= 1'b0; flag_empty <= 1'b1;
    end else if (flush) begin
      count <= '0; rd_ptr <= '0; wr_ptr <= '0;
      flag_full <= 1'b0; flag_empty <= 1'b1;
    end else begin
      count <= cnt_next;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (push_ok && (!lcr[4] || cnt_next == DEPTH_C)) flag_full <= 1'b1;
      else if (pop_req)                                flag_full <= 1'b0;
      if (push_ok)                                     flag_empty <= 1'b0;
      else if (pop_req && cnt_after_pop == '0)         flag_empty <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ris <= '0;
    end else begin
      if (wr && word == W_DATA)                     ris[1] <= 1'b1;
      else if (wr && word == W_ICR && bus_wdata[5]) ris[1] <= 1'b0;
      if (push_ok && cnt_next >= TRIG_C)            ris[0] <= 1'b1;
      else if (wr && word == W_ICR && bus_wdata[4]) ris[0] <= 1'b0;
      else if (pop_req && cnt_after_pop == TRIG_C - 1'b1) ris[0] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ilpr <= '0; ibrd <= '0; fbrd <= '0; lcr <= '0;
      cr <= 32'h300; ifls <= 32'h12; imsc <= '0; dmacr <= '0;
    end else if (wr) begin
      case (word)
        W_ILPR:  ilpr  <= bus_wdata;
        W_IBRD:  ibrd  <= bus_wdata;
        W_FBRD:  fbrd  <= bus_wdata;
        W_LCR:   lcr   <= bus_wdata;
        W_CR:    cr    <= bus_wdata;
        W_IFLS:  ifls  <= bus_wdata;
        W_IMSC:  imsc  <= bus_wdata;
        W_DMACR: dmacr <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0; tx_byte <= '0; bus_err <= 1'b0;
    end else begin
      tx_valid <= wr && (word == W_DATA);
      if (wr && word == W_DATA) tx_byte <= bus_wdata[7:0];
      bus_err <= wr && !wr_known;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_id) begin
      case (word[2:0])
        3'd0: bus_rdata = 32'h11;
        3'd1: bus_rdata = 32'h10;
        3'd2: bus_rdata = 32'h14;
        3'd3: bus_rdata = 32'h00;
        3'd4: bus_rdata = 32'h0D;
        3'd5: bus_rdata = 32'hF0;
        3'd6: bus_rdata = 32'h05;
        default: bus_rdata = 32'hB1;
      endcase
    end else begin
      case (word)
        W_DATA:  bus_rdata = (count != '0) ? {24'h0, mem[rd_ptr]} : 32'h0;
        W_FLAG:  bus_rdata = {24'h0, 1'b1, flag_full, 1'b0, flag_empty, 4'h0};
        W_ILPR:  bus_rdata = ilpr;
        W_IBRD:  bus_rdata = ibrd;
        W_FBRD:  bus_rdata = fbrd;
        W_LCR:   bus_rdata = lcr;
        W_CR:    bus_rdata = cr;
        W_IFLS:  bus_rdata = ifls;
        W_IMSC:  bus_rdata = imsc;
        W_RIS:   bus_rdata = {26'h0, ris, 4'h0};
        W_MIS:   bus_rdata = {26'h0, ris & imsc[5:4], 4'h0};
        W_DMACR: bus_rdata = dmacr;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_regfile_checker.sv
`timescale 1ns/1ps
module uart_regfile_checker #(
  parameter int WRD_W = 10,
  parameter int CNT_W = 5,
  parameter int FIFO_DEPTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_en,
  input logic             bus_we,
  input logic [WRD_W-1:0] word,
  input logic [31:0]      bus_wdata,
  input logic             rx_valid,
  input logic             tx_valid,
  input logic [7:0]       tx_byte,
  input logic             bus_err,
  input logic [CNT_W-1:0] count,
  input logic             fifo_en,
  input logic [1:0]       ris
);
  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[31:8];

  a_r2_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && word == 0) |=> (tx_valid && tx_byte == $past(bus_wdata[7:0]) && ris[1]));

  a_r12_ro_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && (word == 15 || word == 16)) |=> (bus_err && $stable(ris)));

  a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && count == CNT_W'(FIFO_DEPTH) && !bus_en) |=> (count == CNT_W'(FIFO_DEPTH)));

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(FIFO_DEPTH));

  a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && word == 11 && bus_wdata[4] != fifo_en) |=> (count == 0));

  a_r8_clear_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && word == 17 && bus_wdata[5]) |=> !ris[1]);
endmodule

bind uart_regfile uart_regfile_checker #(
  .WRD_W(WRD_W), .CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH)
) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .word(word),
  .bus_wdata(bus_wdata), .rx_valid(rx_valid), .tx_valid(tx_valid), .tx_byte(tx_byte),
  .bus_err(bus_err), .count(count), .fifo_en(lcr[4]), .ris(ris)
);

// File: tb/test_uart_regfile.sv
`timescale 1ns/1ps
module test_uart_regfile;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = '0, tx_byte;
  logic tx_valid, irq, bus_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_regfile i_uart_regfile (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq), .bus_err(bus_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = 12'(idx << 2); bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = 12'(idx << 2);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic rd_chk(input string req, input int idx, input logic [31:0] exp);
    logic [31:0] d;
    rd(idx, d);
    chk(req, d, exp);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_byte = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic t_reset;
    rd_chk("R1 flags", 6, 32'h90);
    rd_chk("R1 control", 12, 32'h300);
    rd_chk("R1 level", 13, 32'h12);
    rd_chk("R1 line", 11, 0);
    rd_chk("R1 mask", 14, 0);
    rd_chk("R1 raw", 15, 0);
    rd_chk("R1 rsr", 1, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_tx;
    wr(0, 32'h1A5);
    chk("R2 tx_valid", tx_valid, 1);
    chk("R2 tx_byte", tx_byte, 8'hA5);
    chk("R2 no err", bus_err, 0);
    @(negedge clk);
    chk("R2 strobe one cycle", tx_valid, 0);
    rd_chk("R2 raw tx", 15, 32'h20);
    chk("R2 irq masked off", irq, 0);
    wr(17, 32'h20);
  endtask

  task automatic t_rx_order;
    push("a"); push("b"); push("c");
    rd_chk("R5 full with queue off", 6, 32'hC0);
    rd_chk("R6 rx raw set", 15, 32'h10);
    rd_chk("R3 first", 0, "a");
    rd_chk("R5 full cleared by read", 6, 32'h80);
    rd_chk("R3 second", 0, "b");
    rd_chk("R3 third", 0, "c");
    rd_chk("R4 empty set", 6, 32'h90);
    rd_chk("R6 rx raw cleared", 15, 32'h0);
    rd_chk("R3 empty read", 0, 0);
  endtask

  task automatic t_full;
    wr(11, 32'h10);
    for (int i = 0; i < 15; i++) push(8'(i + 1));
    rd_chk("R5 not full at 15", 6, 32'h80);
    push(8'd16);
    rd_chk("R5 full at 16", 6, 32'hC0);
    push(8'hEE);
    for (int i = 0; i < 16; i++) rd_chk("R3 drain order", 0, 32'(i + 1));
    rd_chk("R3 dropped push absent", 0, 0);
    rd_chk("R4 empty after drain", 6, 32'h90);
  endtask

  task automatic t_irq;
    wr(14, 32'h30);
    push(8'h5A);
    rd_chk("R8 masked rx", 16, 32'h10);
    chk("R8 irq high", irq, 1);
    wr(17, 32'h10);
    rd_chk("R8 rx cleared", 15, 0);
    chk("R8 irq low", irq, 0);
    push(8'h5B);
    wr(0, 32'h00);
    rd_chk("R8 both raw", 15, 32'h30);
    wr(17, 32'h20);
    rd_chk("R8 only tx cleared", 15, 32'h10);
    wr(14, 32'h20);
    rd_chk("R8 masked none", 16, 0);
    chk("R8 irq follows mask", irq, 0);
    rd_chk("R3 older byte", 0, 32'h5A);
    rd_chk("R6 not cleared at 1", 15, 32'h10);
    rd_chk("R3 newer byte", 0, 32'h5B);
    rd_chk("R6 cleared at 0", 15, 0);
    wr(14, 32'h0);
  endtask

  task automatic t_flush;
    push(8'h01); push(8'h02); push(8'h03);
    wr(11, 32'h70);
    rd_chk("R7 same bit keeps data", 6, 32'h80);
    wr(11, 32'h60);
    rd_chk("R7 toggle empties", 6, 32'h90);
    rd_chk("R7 no stale byte", 0, 0);
    wr(17, 32'h30);
  endtask

  task automatic t_regs;
    int idx[8] = '{8, 9, 10, 11, 12, 13, 14, 18};
    foreach (idx[k]) wr(idx[k], 32'hC0DE0000 | 32'(idx[k]) | (32'(k) << 8));
    foreach (idx[k]) rd_chk("R9 readback", idx[k], 32'hC0DE0000 | 32'(idx[k]) | (32'(k) << 8));
    wr(14, 0);
    wr(11, 0);
  endtask

  task automatic t_misc;
    wr(6, 32'hFFFFFFFF);
    chk("R10 flag write no err", bus_err, 0);
    rd_chk("R10 flags unchanged", 6, 32'h90);
    wr(1, 32'hFF);
    chk("R10 ecr write no err", bus_err, 0);
    rd_chk("R10 rsr zero", 1, 0);
  endtask

  task automatic t_id;
    logic [7:0] exp [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++) rd_chk("R11 id byte", 12'h3F8 + i, 32'(exp[i]));
  endtask

  task automatic t_bad;
    wr(15, 32'h30);
    chk("R12 err on raw write", bus_err, 1);
    @(negedge clk);
    chk("R12 err one cycle", bus_err, 0);
    rd_chk("R12 raw untouched", 15, 0);
    wr(16, 32'h30);
    chk("R12 err on masked write", bus_err, 1);
    wr(12'h3F8, 32'h1);
    chk("R12 err on id write", bus_err, 1);
    rd_chk("R12 id untouched", 12'h3F8, 32'h11);
    wr(3, 32'h1);
    chk("R12 err on gap write", bus_err, 1);
    rd_chk("R12 read icr zero", 17, 0);
    rd_chk("R12 read gap zero", 2, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_tx();
    t_rx_order();
    t_full();
    t_irq();
    t_flush();
    t_regs();
    t_misc();
    t_id();
    t_bad();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule